// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces, one beat per clock, the column addresses that a synchronous DRAM walks through during a read or write burst. A start strobe loads an 8-bit start column, a 3-bit burst-length code and an ordering bit. The block then presents the column of each beat together with a valid flag and a flag that marks the final beat. Fixed bursts of 1, 2, 4 or 8 beats wrap inside their aligned block, in either linear (sequential) or XOR (interleaved) order. A page-length burst walks all 256 columns in a circle until a stop input or a new start ends it.

The same block serves two purposes. In a controller testbench it is the reference model for expected column order. Inside a memory model it is the column counter. A new start on any clock cuts short the burst in progress. Data storage and the delay between a command and its data belong to the surrounding logic.

The output is a stream with a valid flag and no ready. A memory device cannot stall a burst, so the consumer must take every beat that is flagged valid. Start, stop and the mode inputs are plain control pins.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, valid_o and last_o are 0.
- R2: A clock edge with start_i high makes valid_o high from the next cycle on, with col_o equal to the sampled start_col_i as beat 0. A start during an active burst ends that burst and begins the new one. A start takes priority over stop_i on the same edge.
- R3: The length code len_code_i selects the beat count: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives page length. The unused codes 3'b100, 3'b101 and 3'b110 act as length 1. A fixed-length burst that is neither stopped nor restarted stays valid for exactly its beat count and then drops valid_o.
- R4: Sequential order (order_i = 0) in a fixed burst of N beats: the low log2(N) bits of beat i equal (start + i) mod N, and the upper column bits keep their start value.
- R5: Interleaved order (order_i = 1) in a fixed burst of N beats: beat i has column start XOR i, applied to the low log2(N) bits only.
- R6: A page-length burst gives column (start + i) mod 256 for beat i, whatever the value of order_i, and wraps past 255 without ending.
- R7: last_o is high exactly on the final beat of a fixed-length burst. It is never high in a page-length burst.
- R8: stop_i high on an edge during an active burst, with no start on that edge, makes valid_o low from the next cycle. stop_i has no effect while the block is idle.
- R9: start_col_i, len_code_i and order_i are sampled only on a start edge. Changing them during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a burst from start_col_i |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| stop_i | input | 1 | Ends the active burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The assertions assume that rst_n is held low for at least one edge before any start, and that start_i and stop_i are clean levels sampled on the rising edge. Nothing else is assumed about the inputs. Any mix of start, stop and mode changes is legal, including a stop while idle and a start on every clock.

The stimulus drives all inputs on the falling edge. It mixes random starts, stops and mode values, including the three unused length codes, with directed bursts. The directed bursts cover wrap at a block edge, the 255-to-0 wrap of a page burst, and a start and a stop on the same edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  localparam int unsigned LEN_CODE_W = 3;
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec #(
  parameter int unsigned COL_W = 8
) (
  input  logic [bcg_pkg::LEN_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]               span_mask_o,
  output logic                           page_o
);
  import bcg_pkg::*;

  // span_mask holds the column bits that move during a fixed burst
  always_comb begin
    span_mask_o = '0;
    page_o      = 1'b0;
    unique case (code_i)
      BL_TWO:   span_mask_o = COL_W'(1);
      BL_FOUR:  span_mask_o = COL_W'(3);
      BL_EIGHT: span_mask_o = COL_W'(7);
      BL_PAGE: begin
        span_mask_o = '1;
        page_o      = 1'b1;
      end
      default:  span_mask_o = '0;   // length 1 and unused codes
    endcase
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             page_i,
  input  logic [COL_W-1:0] span_mask_i,
  output logic [COL_W-1:0] beat_o,
  output logic             active_o,
  output logic             last_o
);
  logic final_beat;

  assign final_beat = active_o && !page_i && (beat_o == span_mask_i);
  assign last_o     = final_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      beat_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
    end else if (active_o) begin
      if (stop_i || final_beat) begin
        active_o <= 1'b0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_o);                                        // R7
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && page_i) |-> !last_o);                           // R7
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !active_o);                         // R3
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && active_o && !start_i) |=> !active_o);             // R8
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && !stop_i && !last_o) |=> (active_o && beat_o == $past(beat_o) + 1'b1)); // R6
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] span_mask_i,
  input  logic             page_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o
);
  import bcg_pkg::*;

  logic [COL_W-1:0] linear;

  assign linear = base_i + beat_i;

  // Each column bit picks its source independently
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (page_i)
        col_o[b] = linear[b];
      else if (!span_mask_i[b])
        col_o[b] = base_i[b];
      else if (order_i == ORD_ILV)
        col_o[b] = base_i[b] ^ beat_i[b];
      else
        col_o[b] = linear[b];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [COL_W-1:0]               start_col_i,
  input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code_i,
  input  logic                           order_i,
  input  logic                           stop_i,
  output logic [COL_W-1:0]               col_o,
  output logic                           valid_o,
  output logic                           last_o
);
  logic [COL_W-1:0]               base_q;
  logic [bcg_pkg::LEN_CODE_W-1:0] code_q;
  logic                           order_q;
  logic [COL_W-1:0]               span_mask;
  logic                           page;
  logic [COL_W-1:0]               beat;

  // Burst parameters are captured only on a start edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      code_q  <= '0;
      order_q <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      code_q  <= len_code_i;
      order_q <= order_i;
    end
  end

  bcg_mode_dec #(.COL_W(COL_W)) i_dec (
    .code_i      (code_q),
    .span_mask_o (span_mask),
    .page_o      (page)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .page_i      (page),
    .span_mask_i (span_mask),
    .beat_o      (beat),
    .active_o    (valid_o),
    .last_o      (last_o)
  );

  bcg_col_calc #(.COL_W(COL_W)) i_calc (
    .base_i      (base_q),
    .beat_i      (beat),
    .span_mask_i (span_mask),
    .page_i      (page),
    .order_i     (order_q),
    .col_o       (col_o)
  );

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));       // R2
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i && !stop_i && !last_o && !page) |=> (((col_o ^ $past(col_o)) & ~span_mask) == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);                        // R8
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] code = '0;
  logic       ord = 1'b0;
  logic       stp = 1'b0;
  logic [7:0] col;
  logic       valid;
  logic       last;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(code), .order_i(ord), .stop_i(stp),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  // Expected behaviour from the requirements
  function automatic int beats_of(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] b, input int i,
                                         input logic [2:0] c, input logic o);
    int n;
    n = beats_of(c);
    if (c == 3'b111) return 8'((int'(b) + i) % 256);
    if (o) return b ^ 8'(i);
    return 8'((int'(b) / n) * n + ((int'(b) % n) + i) % n);
  endfunction

  logic       m_v = 1'b0;
  logic [7:0] m_base = '0;
  int         m_i = 0;
  logic [2:0] m_code = '0;
  logic       m_ord = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) m_v <= 1'b0;
    else if (start) begin
      m_v <= 1'b1; m_base <= scol; m_i <= 0; m_code <= code; m_ord <= ord;
    end else if (m_v) begin
      if (stp) m_v <= 1'b0;
      else if (m_code != 3'b111 && m_i == beats_of(m_code) - 1) m_v <= 1'b0;
      else m_i <= (m_i + 1) % 256;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare outputs with the model; called at a falling edge
  task automatic compare();
    logic m_last;
    logic [7:0] ec;
    m_last = m_v && m_code != 3'b111 && m_i == beats_of(m_code) - 1;
    chk(valid == m_v, "R2 R3 R8 valid", valid, m_v);
    chk(last == m_last, "R7 last", last, m_last);
    if (m_v) begin
      ec = exp_col(m_base, m_i, m_code, m_ord);
      if (m_code == 3'b111)   chk(col == ec, "R6 page col", col, ec);
      else if (m_ord)         chk(col == ec, "R5 interleaved col", col, ec);
      else                    chk(col == ec, "R4 sequential col", col, ec);
    end
  endtask

  task automatic cyc(input logic st, input logic [7:0] c, input logic [2:0] lc,
                     input logic o, input logic sp);
    start = st; scol = c; code = lc; ord = o; stp = sp;
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk(valid == 1'b0 && last == 1'b0, "R1 reset", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R1 after reset", valid, 0);
    // R8: stop while idle has no effect
    cyc(0, 8'h00, 3'b000, 0, 1);
    chk(valid == 1'b0, "R8 idle stop", valid, 0);
    // R4: sequential 8 starting mid block
    cyc(1, 8'h5D, 3'b011, 0, 0);
    chk(col == 8'h5D, "R2 first beat", col, 8'h5D);
    // R9: change inputs mid burst without start
    for (int k = 0; k < 8; k++) cyc(0, 8'hFF, 3'b111, 1, 0);
    // R5: interleaved 4
    cyc(1, 8'hA6, 3'b010, 1, 0);
    for (int k = 0; k < 4; k++) cyc(0, 8'h00, 3'b000, 0, 0);
    // R6: page burst wrapping past 255, then stop
    cyc(1, 8'hFC, 3'b111, 1, 0);
    for (int k = 0; k < 6; k++) cyc(0, 8'h00, 3'b000, 0, 0);
    chk(col == 8'h02, "R6 wrap", col, 8'h02);
    cyc(0, 8'h00, 3'b000, 0, 1);
    chk(valid == 1'b0, "R8 stop page", valid, 0);
    // R3: unused code acts as length 1
    cyc(1, 8'h33, 3'b101, 0, 0);
    chk(last == 1'b1, "R3 unused code", last, 1);
    // R2: start and stop together, start wins; truncation
    cyc(1, 8'h10, 3'b011, 0, 0);
    cyc(1, 8'h20, 3'b001, 0, 1);
    chk(valid && col == 8'h20, "R2 start beats stop", col, 8'h20);
    cyc(0, 8'h00, 3'b000, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic st, sp;
      st = ($urandom % 10) == 0;
      sp = ($urandom % 24) == 0;
      cyc(st, 8'($urandom), 3'($urandom), 1'($urandom), sp);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule